// File: doc/BRIEF.md
# UART Receive Buffer with Level and Idle Interrupts

This block stores bytes delivered by a UART receiver in a 32-entry first-in first-out buffer. A host pops them one at a time. Two interrupt sources tell the host when to come and read.

The first source is a fill-level interrupt. It is asserted while the number of stored bytes is at or above a threshold, and the host picks that threshold as a fraction of the depth through a 3-bit level code. The second source is an idle timeout. It is raised when unread bytes have waited through a fixed number of bit periods with no new byte and no host read. This lets a short trailing message reach the host even though it never reaches the level threshold.

Each source has its own enable, and a combined line reports either one. A byte that arrives while the buffer is full is discarded and leaves a sticky overflow indication. The status bits have no software write path, so only buffer and timing events can set them.

Top module: `uart_rx_fifo_irq`

## Requirements
- R1: After reset the buffer is empty (empty=1, full=0), overflow=0, irq_level=0, irq_tmo=0, irq_any=0, and the level code is 3'b010.
- R2: Bytes leave in the order they arrived, up to 32 stored. rd_data shows the oldest byte whenever empty=0, and rd_en pops it. An rd_en while empty has no effect.
- R3: A byte with rx_valid while 32 are stored is not stored, and overflow becomes 1 on the next cycle. overflow stays 1 until an ovf_clr pulse, which clears it.
- R4: Level codes 3'b000, 3'b001, 3'b010, 3'b011 and 3'b100 set thresholds of 4, 8, 16, 24 and 28 bytes. When enabled, irq_level is 1 from the cycle after the occupancy reaches the threshold.
- R5: Level codes 3'b101, 3'b110 and 3'b111 behave as 3'b010 (threshold 16). The level code is loaded from lvl_wdata on a cycle with lvl_wr=1.
- R6: irq_level returns to 0 in the cycle after a host read brings occupancy below the threshold.
- R7: While the buffer is non-empty, the timeout becomes pending after the 32nd bit_tick pulse with no rx_valid and no rd_en since the last restart. bit_tick pulses while the buffer is empty never raise it.
- R8: Every rx_valid and every rd_en restarts the 32-tick count from zero.
- R9: A pending timeout clears on a tmo_clr pulse, or when the buffer becomes empty. After tmo_clr, a further 32 idle ticks raise it again.
- R10: irq_level and irq_tmo are each gated by their own enable (irq_en_level, irq_en_tmo, 1 = enabled). irq_any is their OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on rx_data |
| rx_data | input | 8 | Received byte |
| bit_tick | input | 1 | One-cycle pulse per serial bit period |
| rd_en | input | 1 | Host pop strobe |
| rd_data | output | 8 | Oldest stored byte |
| lvl_wr | input | 1 | Load strobe for the level code |
| lvl_wdata | input | 3 | New level code |
| irq_en_level | input | 1 | Enable for the level interrupt |
| irq_en_tmo | input | 1 | Enable for the timeout interrupt |
| tmo_clr | input | 1 | Acknowledge pulse that clears a pending timeout |
| ovf_clr | input | 1 | Clear pulse for the overflow flag |
| empty | output | 1 | Buffer holds no bytes |
| full | output | 1 | Buffer holds 32 bytes |
| overflow | output | 1 | Sticky: a byte was dropped |
| irq_level | output | 1 | Enabled fill-level interrupt |
| irq_tmo | output | 1 | Enabled idle-timeout interrupt |
| irq_any | output | 1 | OR of the two enabled interrupts |

## Verification
Suppose the occupancy count drifts away from the true number of stored bytes. The error shows in the very next cycle as irq_level switching one byte early or late against the decoded threshold. Later it shows as empty or full at the wrong push count, or as a byte out of order on rd_data. A wrong timeout count is seen as irq_tmo rising on a tick other than the 32nd idle one, or failing to restart after a push or pop. A wrong overflow state shows as the flag rising without a drop, a dropped byte reappearing in the read stream, or the flag falling without ovf_clr.

// File: rtl/uart_rxirq_pkg.sv
package uart_rxirq_pkg;

    typedef enum logic [2:0] {
        LVL_EIGHTH       = 3'b000,
        LVL_QUARTER      = 3'b001,
        LVL_HALF         = 3'b010,
        LVL_THREE_QUART  = 3'b011,
        LVL_SEVEN_EIGHTH = 3'b100
    } rx_lvl_e;

    localparam logic [2:0] LVL_RESET = LVL_HALF;

endpackage

// File: rtl/rxirq_store.sv
module rxirq_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/rxirq_thresh.sv
module rxirq_thresh
    import uart_rxirq_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic [2:0]    lvl,
    output logic [CW-1:0] thr
);

    localparam int UNIT = DEPTH / 8;

    int eighths;

    always_comb begin
        case (lvl)
            LVL_EIGHTH:       eighths = 1;
            LVL_QUARTER:      eighths = 2;
            LVL_HALF:         eighths = 4;
            LVL_THREE_QUART:  eighths = 6;
            LVL_SEVEN_EIGHTH: eighths = 7;
            default:          eighths = 4;   // reserved codes fall back to half
        endcase
        thr = CW'(UNIT * eighths);
    end

endmodule

// File: rtl/rxirq_tmo.sv
module rxirq_tmo #(
    parameter int TMO_BITS = 32,
    localparam int TW      = $clog2(TMO_BITS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic restart,
    input  logic tick,
    input  logic clr,
    input  logic drained,
    output logic pend
);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          pend;
    } tmo_state_t;

    tmo_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (clr || drained) begin
            st_d.pend = 1'b0;
        end
        if (restart || !active) begin
            st_d.cnt = '0;
        end else if (tick && !st_q.pend) begin
            if (st_q.cnt == TW'(TMO_BITS - 1)) begin
                st_d.cnt  = '0;
                st_d.pend = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;

endmodule

// File: rtl/uart_rx_fifo_irq.sv
module uart_rx_fifo_irq
    import uart_rxirq_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 32,
    parameter int TMO_BITS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              bit_tick,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              lvl_wr,
    input  logic [2:0]        lvl_wdata,
    input  logic              irq_en_level,
    input  logic              irq_en_tmo,
    input  logic              tmo_clr,
    input  logic              ovf_clr,
    output logic              empty,
    output logic              full,
    output logic              overflow,
    output logic              irq_level,
    output logic              irq_tmo,
    output logic              irq_any
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
        logic [2:0]    lvl;
        logic          ovf;
    } buf_state_t;

    buf_state_t st_q, st_d;

    logic          push, pop;
    logic [CW-1:0] thr;
    logic          tmo_pend_q;

    always_comb begin
        st_d = st_q;
        push = rx_valid && (st_q.count != DEPTH_C);
        pop  = rd_en && (st_q.count != '0);
        if (push) st_d.wr_ptr = st_q.wr_ptr + 1'b1;
        if (pop)  st_d.rd_ptr = st_q.rd_ptr + 1'b1;
        st_d.count = st_q.count + CW'(push) - CW'(pop);
        if (lvl_wr) st_d.lvl = lvl_wdata;
        st_d.ovf = (st_q.ovf && !ovf_clr) || (rx_valid && (st_q.count == DEPTH_C));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.lvl    <= LVL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    rxirq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (push),
        .waddr (st_q.wr_ptr),
        .wdata (rx_data),
        .raddr (st_q.rd_ptr),
        .rdata (rd_data)
    );

    rxirq_thresh #(.DEPTH(DEPTH)) u_thresh (
        .lvl (st_q.lvl),
        .thr (thr)
    );

    rxirq_tmo #(.TMO_BITS(TMO_BITS)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (st_q.count != '0),
        .restart (rx_valid || rd_en),
        .tick    (bit_tick),
        .clr     (tmo_clr),
        .drained (st_d.count == '0),
        .pend    (tmo_pend_q)
    );

    assign empty     = (st_q.count == '0);
    assign full      = (st_q.count == DEPTH_C);
    assign overflow  = st_q.ovf;
    assign irq_level = irq_en_level && (st_q.count >= thr);
    assign irq_tmo   = irq_en_tmo && tmo_pend_q;
    assign irq_any   = irq_level || irq_tmo;

endmodule

// File: rtl/rxirq_checker.sv
module rxirq_checker (
    input logic clk,
    input logic rst_n,
    input logic rx_valid,
    input logic rd_en,
    input logic bit_tick,
    input logic ovf_clr,
    input logic irq_en_level,
    input logic irq_en_tmo,
    input logic empty,
    input logic full,
    input logic overflow,
    input logic irq_level,
    input logic irq_tmo
);

    a_r2_empty_full_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    a_r2_empty_read_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !rx_valid) |=> empty);

    a_r3_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rx_valid && !rd_en) |=> full);

    a_r3_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !$past(overflow)) |-> $past(full && rx_valid));

    a_r3_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(overflow) && !$past(ovf_clr)) |-> overflow);

    a_r9_tmo_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tmo |-> !empty);

    a_r7_tmo_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_tmo) && $past(irq_en_tmo)) |-> $past(bit_tick && !rx_valid && !rd_en));

    a_r10_level_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_level |-> !irq_level);

    a_r10_tmo_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_tmo |-> !irq_tmo);

endmodule

bind uart_rx_fifo_irq rxirq_checker u_rxirq_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rd_en        (rd_en),
    .bit_tick     (bit_tick),
    .ovf_clr      (ovf_clr),
    .irq_en_level (irq_en_level),
    .irq_en_tmo   (irq_en_tmo),
    .empty        (empty),
    .full         (full),
    .overflow     (overflow),
    .irq_level    (irq_level),
    .irq_tmo      (irq_tmo)
);

// File: tb/uart_rx_fifo_irq_bench.sv
module uart_rx_fifo_irq_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       bit_tick = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       lvl_wr = 1'b0;
    logic [2:0] lvl_wdata = '0;
    logic       irq_en_level = 1'b1;
    logic       irq_en_tmo = 1'b1;
    logic       tmo_clr = 1'b0;
    logic       ovf_clr = 1'b0;
    logic       empty, full, overflow, irq_level, irq_tmo, irq_any;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_rx_fifo_irq u_uart_rx_fifo_irq (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .bit_tick(bit_tick), .rd_en(rd_en), .rd_data(rd_data),
        .lvl_wr(lvl_wr), .lvl_wdata(lvl_wdata),
        .irq_en_level(irq_en_level), .irq_en_tmo(irq_en_tmo),
        .tmo_clr(tmo_clr), .ovf_clr(ovf_clr),
        .empty(empty), .full(full), .overflow(overflow),
        .irq_level(irq_level), .irq_tmo(irq_tmo), .irq_any(irq_any)
    );

    // {level code, expected threshold in bytes}
    localparam logic [8:0] LVL_TAB [8] = '{
        {3'b000, 6'd4},  {3'b001, 6'd8},  {3'b010, 6'd16}, {3'b011, 6'd24},
        {3'b100, 6'd28}, {3'b101, 6'd16}, {3'b110, 6'd16}, {3'b111, 6'd16}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        rx_valid = 1'b1; rx_data = b;
        step();
        rx_valid = 1'b0;
    endtask

    task automatic pop();
        rd_en = 1'b1;
        step();
        rd_en = 1'b0;
    endtask

    task automatic drain();
        while (!empty) pop();
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            bit_tick = 1'b1;
            step();
            bit_tick = 1'b0;
        end
    endtask

    task automatic set_lvl(input logic [2:0] c);
        lvl_wr = 1'b1; lvl_wdata = c;
        step();
        lvl_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 empty", empty, 1);
        chk("R1 full", full, 0);
        chk("R1 overflow", overflow, 0);
        chk("R1 irq_level", irq_level, 0);
        chk("R1 irq_tmo", irq_tmo, 0);
        chk("R1 irq_any", irq_any, 0);

        // R1 default code is half: 15 bytes below, 16 at threshold
        for (int i = 0; i < 15; i++) push(8'(i + 1));
        chk("R1 default below half", irq_level, 0);
        push(8'd16);
        chk("R1 default at half", irq_level, 1);
        chk("R10 any follows level", irq_any, 1);
        irq_en_level = 1'b0;
        @(negedge clk);
        chk("R10 level gated", irq_level, 0);
        chk("R10 any gated", irq_any, 0);
        irq_en_level = 1'b1;
        @(negedge clk);
        chk("R2 first out", rd_data, 8'd1);
        pop();
        chk("R6 level drops after read", irq_level, 0);
        for (int i = 2; i <= 16; i++) begin
            chk("R2 order", rd_data, 8'(i));
            pop();
        end
        chk("R2 empty after drain", empty, 1);
        pop();
        chk("R2 read on empty ignored", empty, 1);
        push(8'hA5);
        chk("R2 show-ahead after empty read", rd_data, 8'hA5);
        drain();

        // R4 / R5 / R6 table walk
        for (int t = 0; t < 8; t++) begin
            logic [2:0] code;
            int thr;
            code = LVL_TAB[t][8:6];
            thr  = int'(LVL_TAB[t][5:0]);
            set_lvl(code);
            for (int j = 0; j < thr - 1; j++) push(8'(j));
            chk($sformatf("R4 R5 code %0d below", code), irq_level, 0);
            push(8'hEE);
            chk($sformatf("R4 R5 code %0d at threshold", code), irq_level, 1);
            pop();
            chk($sformatf("R6 code %0d after read", code), irq_level, 0);
            drain();
        end

        // R3 full and overflow
        set_lvl(3'b010);
        for (int i = 0; i < 32; i++) push(8'(8'h40 + i));
        chk("R3 full at 32", full, 1);
        chk("R3 no overflow yet", overflow, 0);
        push(8'hFF);
        chk("R3 overflow set", overflow, 1);
        chk("R3 still full", full, 1);
        for (int i = 0; i < 32; i++) begin
            chk("R3 dropped byte absent", rd_data, 8'(8'h40 + i));
            pop();
        end
        chk("R3 empty after drain", empty, 1);
        chk("R3 overflow sticky", overflow, 1);
        ovf_clr = 1'b1; step(); ovf_clr = 1'b0;
        chk("R3 overflow cleared", overflow, 0);

        // R7 idle ticks on empty buffer
        ticks(40);
        chk("R7 no timeout when empty", irq_tmo, 0);

        // R7 timeout after 32 idle ticks
        push(8'h11);
        ticks(31);
        chk("R7 not at 31 ticks", irq_tmo, 0);
        ticks(1);
        chk("R7 at 32 ticks", irq_tmo, 1);
        chk("R10 any follows timeout", irq_any, 1);
        irq_en_tmo = 1'b0;
        @(negedge clk);
        chk("R10 timeout gated", irq_tmo, 0);
        irq_en_tmo = 1'b1;
        @(negedge clk);

        // R9 clear and re-raise, then empty clears
        tmo_clr = 1'b1; step(); tmo_clr = 1'b0;
        chk("R9 cleared by ack", irq_tmo, 0);
        ticks(32);
        chk("R9 re-raised after ack", irq_tmo, 1);
        pop();
        chk("R9 cleared when empty", irq_tmo, 0);

        // R8 restart by a received byte
        push(8'h21);
        ticks(20);
        push(8'h22);
        ticks(20);
        chk("R8 restart on byte", irq_tmo, 0);
        ticks(12);
        chk("R8 fires 32 after byte", irq_tmo, 1);

        // R8 restart by a host read
        tmo_clr = 1'b1; step(); tmo_clr = 1'b0;
        ticks(20);
        pop();
        ticks(20);
        chk("R8 restart on read", irq_tmo, 0);
        ticks(12);
        chk("R8 fires 32 after read", irq_tmo, 1);
        drain();
        chk("R9 drained clears", irq_tmo, 0);

        finish_run();
    end

endmodule